// File: doc/BRIEF.md
# Compare Channel with Pulse-Width Modulation

This block is one compare channel that sits beside its own free-running timer. The timer counts up from zero to a programmable period value and then wraps to zero. On every timer value the channel compares the count with a compare register. Depending on the selected mode, a match sets, clears or toggles one output pin, or the channel produces a pulse-width modulated waveform whose period comes from the timer.

In the pulse-width mode the duty value is double-buffered. Software writes a shadow register at any time. The working compare register takes that value only when the timer reaches its period value, so a duty change never cuts a pulse short or stretches one.

Two sticky event flags report activity. The compare flag reports matches in the non-PWM modes. The timer flag reports period boundaries in every mode. Each flag has an enable bit. The single interrupt request is active while any enabled flag is set.

Top module: `ocpwm_channel`

## Requirements
- R1: The timer resets to 0 and counts up by one per clock. In the cycle after its count equals the period register, it holds 0.
- R2: Mode field codes are 0 = off (pin low), 1 = drive pin high on a match, 2 = drive pin low on a match, 3 = invert pin on a match, 4 = pulse-width mode. Codes 5 to 7 behave as off. In modes 1 to 3 the pin changes in the cycle after the count equals the compare register.
- R3: A match between count and compare register sets the compare flag in modes 1 to 3 only. The flag never becomes set in the off or pulse-width modes.
- R4: The timer flag becomes set in the cycle after each count-equals-period event, in every mode.
- R5: Both flags stay set until cleared by a write to address 5 (bit 0 clears the compare flag, bit 1 clears the timer flag). If a clear and a set of the same flag fall in one cycle, the flag ends up set.
- R6: irq is high exactly while (compare flag AND enable bit 0) OR (timer flag AND enable bit 1). The enable bits are written at address 4.
- R7: In pulse-width mode the pin is high in each cycle whose count is below the compare register and low otherwise. A duty of 0 keeps the pin low, and a duty above the period keeps it high.
- R8: In pulse-width mode the compare register loads the shadow register when the count equals the period. A shadow write has no effect on the pin before that event.
- R9: The write port decodes address 0 = mode, 1 = compare, 2 = shadow, 3 = period. A write takes effect one cycle later. After reset the mode, compare and shadow registers are 0, both flags and enables are 0, the period register holds all ones, and pin and irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| pin_out | output | 1 | Channel output pin |
| irq | output | 1 | Interrupt request |

## Verification
The compare modes run with a fixed compare value that lies inside the period. This separates the set, clear and invert behaviours through the pin level each cycle after a match. The pulse-width mode is swept across duty values of zero, inside the period, equal to the period and beyond it. These show the always-low, normal, one-short and always-high waveforms. Shadow writes are placed in the middle of a period to show that the pulse in progress keeps its width. Clears are placed exactly on a period event, and enables are toggled while flags are held, which separates flag state from interrupt gating.

// File: rtl/ocpwm_pkg.sv
package ocpwm_pkg;
  localparam logic [2:0] MODE_OFF = 3'd0;
  localparam logic [2:0] MODE_SET = 3'd1;
  localparam logic [2:0] MODE_CLR = 3'd2;
  localparam logic [2:0] MODE_TOG = 3'd3;
  localparam logic [2:0] MODE_PWM = 3'd4;

  localparam logic [2:0] ADDR_MODE   = 3'd0;
  localparam logic [2:0] ADDR_CMP    = 3'd1;
  localparam logic [2:0] ADDR_SHADOW = 3'd2;
  localparam logic [2:0] ADDR_PERIOD = 3'd3;
  localparam logic [2:0] ADDR_ENABLE = 3'd4;
  localparam logic [2:0] ADDR_CLEAR  = 3'd5;

  function automatic logic is_match_mode(input logic [2:0] m);
    return (m == MODE_SET) || (m == MODE_CLR) || (m == MODE_TOG);
  endfunction
endpackage

// File: rtl/ocpwm_timebase.sv
module ocpwm_timebase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic [W-1:0] count_next,
  output logic         period_match
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] c, input logic [W-1:0] p);
    return (c == p) ? '0 : c + 1'b1;
  endfunction

  assign period_match = (count == period);
  assign count_next   = advance(count, period);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_next;
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    period_match |=> (count == '0));
endmodule

// File: rtl/ocpwm_regs.sv
module ocpwm_regs
  import ocpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         period_match,
  output logic [2:0]   mode,
  output logic [W-1:0] primary,
  output logic [W-1:0] primary_next,
  output logic [W-1:0] period,
  output logic         cmp_ie,
  output logic         tmr_ie,
  output logic         clr_cmp,
  output logic         clr_tmr
);
  logic [W-1:0] shadow;
  logic         shadow_load;

  function automatic logic hit(input logic en, input logic [2:0] a, input logic [2:0] want);
    return en && (a == want);
  endfunction

  assign shadow_load = (mode == MODE_PWM) && period_match;
  assign clr_cmp     = hit(wr_en, wr_addr, ADDR_CLEAR) && wr_data[0];
  assign clr_tmr     = hit(wr_en, wr_addr, ADDR_CLEAR) && wr_data[1];

  always_comb begin
    primary_next = primary;
    if (shadow_load)                         primary_next = shadow;
    else if (hit(wr_en, wr_addr, ADDR_CMP))  primary_next = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_OFF;
      primary <= '0;
      shadow  <= '0;
      period  <= '1;
      cmp_ie  <= 1'b0;
      tmr_ie  <= 1'b0;
    end else begin
      primary <= primary_next;
      if (hit(wr_en, wr_addr, ADDR_MODE))   mode   <= wr_data[2:0];
      if (hit(wr_en, wr_addr, ADDR_SHADOW)) shadow <= wr_data;
      if (hit(wr_en, wr_addr, ADDR_PERIOD)) period <= wr_data;
      if (hit(wr_en, wr_addr, ADDR_ENABLE)) begin
        cmp_ie <= wr_data[0];
        tmr_ie <= wr_data[1];
      end
    end
  end

  assert_shadow_load_R8: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_PWM) && period_match) |=> (primary == $past(shadow)));
endmodule

// File: rtl/ocpwm_pin.sv
module ocpwm_pin
  import ocpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   mode,
  input  logic         compare_match,
  input  logic [W-1:0] count,
  input  logic [W-1:0] primary,
  input  logic [W-1:0] count_next,
  input  logic [W-1:0] primary_next,
  output logic         pin
);
  logic pin_d;

  function automatic logic pwm_level(input logic [W-1:0] c, input logic [W-1:0] duty);
    return c < duty;
  endfunction

  always_comb begin
    case (mode)
      MODE_SET: pin_d = compare_match ? 1'b1 : pin;
      MODE_CLR: pin_d = compare_match ? 1'b0 : pin;
      MODE_TOG: pin_d = compare_match ? ~pin : pin;
      MODE_PWM: pin_d = pwm_level(count_next, primary_next);
      default:  pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= pin_d;
  end

  assert_off_low_R2: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_OFF) || (mode > MODE_PWM)) |=> !pin);
  assert_pwm_level_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == MODE_PWM) |-> (pin == (count < primary)));
endmodule

// File: rtl/ocpwm_flags.sv
module ocpwm_flags
  import ocpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       compare_match,
  input  logic       period_match,
  input  logic       clr_cmp,
  input  logic       clr_tmr,
  input  logic       cmp_ie,
  input  logic       tmr_ie,
  output logic       irq
);
  logic cmp_flag, tmr_flag, cmp_set;

  assign cmp_set = compare_match && is_match_mode(mode);
  assign irq     = (cmp_flag && cmp_ie) || (tmr_flag && tmr_ie);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_flag <= 1'b0;
      tmr_flag <= 1'b0;
    end else begin
      cmp_flag <= cmp_set      || (cmp_flag && !clr_cmp);
      tmr_flag <= period_match || (tmr_flag && !clr_tmr);
    end
  end

  assert_cmp_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!is_match_mode(mode)) |=> !$rose(cmp_flag));
  assert_cmp_set_R3: assert property (@(posedge clk) disable iff (rst)
    (compare_match && is_match_mode(mode)) |=> cmp_flag);
  assert_tmr_set_R4: assert property (@(posedge clk) disable iff (rst)
    period_match |=> tmr_flag);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !clr_cmp) |=> cmp_flag);
endmodule

// File: rtl/ocpwm_channel.sv
module ocpwm_channel
  import ocpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pin_out,
  output logic         irq
);
  logic [W-1:0] count, count_next, primary, primary_next, period;
  logic [2:0]   mode;
  logic         period_match, compare_match;
  logic         cmp_ie, tmr_ie, clr_cmp, clr_tmr;

  assign compare_match = (count == primary);

  ocpwm_timebase #(.W(W)) u_timebase (
    .clk(clk), .rst(rst), .period(period), .count(count),
    .count_next(count_next), .period_match(period_match));

  ocpwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period_match(period_match), .mode(mode), .primary(primary),
    .primary_next(primary_next), .period(period), .cmp_ie(cmp_ie),
    .tmr_ie(tmr_ie), .clr_cmp(clr_cmp), .clr_tmr(clr_tmr));

  ocpwm_pin #(.W(W)) u_pin (
    .clk(clk), .rst(rst), .mode(mode), .compare_match(compare_match),
    .count(count), .primary(primary), .count_next(count_next),
    .primary_next(primary_next), .pin(pin_out));

  ocpwm_flags u_flags (
    .clk(clk), .rst(rst), .mode(mode), .compare_match(compare_match),
    .period_match(period_match), .clr_cmp(clr_cmp), .clr_tmr(clr_tmr),
    .cmp_ie(cmp_ie), .tmr_ie(tmr_ie), .irq(irq));
endmodule

// File: tb/test_ocpwm_channel.sv
module test_ocpwm_channel;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         pin_out, irq;

  int checks = 0;
  int fails  = 0;
  string tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  ocpwm_channel #(.W(W)) i_ocpwm_channel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_out(pin_out), .irq(irq));

  // Reference state kept from the requirements
  logic [W-1:0] m_tmr, m_per, m_pri, m_sec;
  logic [2:0]   m_mode;
  logic         m_pin, m_cf, m_tf, m_cie, m_tie;
  logic [1:0]   exp_q[$];
  string        tag_q[$];

  always @(posedge clk) begin : model
    logic pm, cm, wm, npin, ncf, ntf, ncie, ntie;
    logic [W-1:0] nt, npri;
    if (rst) begin
      m_tmr <= '0; m_per <= '1; m_pri <= '0; m_sec <= '0; m_mode <= 3'd0;
      m_pin <= 1'b0; m_cf <= 1'b0; m_tf <= 1'b0; m_cie <= 1'b0; m_tie <= 1'b0;
    end else begin
      pm = (m_tmr == m_per);
      cm = (m_tmr == m_pri);
      nt = pm ? '0 : m_tmr + 1'b1;
      npri = (m_mode == 3'd4 && pm) ? m_sec : ((wr_en && wr_addr == 3'd1) ? wr_data : m_pri);
      wm = (m_mode >= 3'd1 && m_mode <= 3'd3);
      case (m_mode)
        3'd1: npin = cm ? 1'b1 : m_pin;
        3'd2: npin = cm ? 1'b0 : m_pin;
        3'd3: npin = cm ? ~m_pin : m_pin;
        3'd4: npin = (nt < npri);
        default: npin = 1'b0;
      endcase
      ncf = (cm && wm) | (m_cf & ~(wr_en && wr_addr == 3'd5 && wr_data[0]));
      ntf = pm | (m_tf & ~(wr_en && wr_addr == 3'd5 && wr_data[1]));
      ncie = (wr_en && wr_addr == 3'd4) ? wr_data[0] : m_cie;
      ntie = (wr_en && wr_addr == 3'd4) ? wr_data[1] : m_tie;
      m_tmr <= nt; m_pri <= npri; m_pin <= npin; m_cf <= ncf; m_tf <= ntf;
      m_cie <= ncie; m_tie <= ntie;
      if (wr_en && wr_addr == 3'd0) m_mode <= wr_data[2:0];
      if (wr_en && wr_addr == 3'd2) m_sec  <= wr_data;
      if (wr_en && wr_addr == 3'd3) m_per  <= wr_data;
      exp_q.push_back({npin, (ncf & ncie) | (ntf & ntie)});
      tag_q.push_back(tag);
    end
  end

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({pin_out, irq} !== e) begin
        fails++;
        $display("FAIL %s: pin/irq got %b%b expected %b%b at %0t", t, pin_out, irq, e[1], e[0], $time);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_when_count(input logic [W-1:0] c, input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    while (m_tmr != c) @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pin_out !== 1'b0) begin fails++; $display("FAIL R9: reset pin got %b expected 0", pin_out); end
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R9: reset irq got %b expected 0", irq); end
    rst = 1'b0;
    tag = "R9 R1";  wr(3'd3, 8'd9); wr(3'd4, 8'd2);
    tag = "R1 R4 R6"; idle(25); wr(3'd5, 8'd2); idle(5);
    tag = "R5";     wr_when_count(8'd9, 3'd5, 8'd2); idle(12); wr(3'd5, 8'd2); idle(3);
    tag = "R6";     wr(3'd4, 8'd0); idle(12); wr(3'd4, 8'd2); idle(2); wr(3'd5, 8'd3);
    tag = "R2 R3";  wr(3'd4, 8'd1); wr(3'd1, 8'd4); wr(3'd0, 8'd1); idle(25);
    wr(3'd5, 8'd1); idle(3); wr(3'd0, 8'd2); idle(25); wr(3'd5, 8'd1);
    wr(3'd0, 8'd3); idle(40); wr(3'd5, 8'd1);
    tag = "R5";     wr_when_count(8'd4, 3'd5, 8'd1); idle(5);
    tag = "R2 R3";  wr(3'd0, 8'd6); idle(3); wr(3'd5, 8'd1); idle(15);
    tag = "R7 R8";  wr(3'd2, 8'd3); wr(3'd0, 8'd4); idle(30);
    tag = "R3 R7";  wr(3'd5, 8'd1); idle(25);
    tag = "R7";     wr(3'd2, 8'd0); idle(25); wr(3'd2, 8'd12); idle(25);
    wr(3'd2, 8'd9); idle(22); wr(3'd2, 8'd10); idle(22);
    tag = "R8";     wr(3'd2, 8'd6); idle(22); wr_when_count(8'd2, 3'd2, 8'd1); idle(25);
    tag = "R1 R7";  wr(3'd3, 8'd5); idle(20); wr(3'd2, 8'd2); wr(3'd3, 8'd3); idle(20);
    tag = "R2";     wr(3'd0, 8'd0); idle(10);
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule